// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the interrupt state of a single processor across 256 vectors. For each vector it records whether a request is waiting, whether the vector is being serviced, and whether it arrived level- or edge-triggered. Software sets a task priority. The block combines that task priority with the class of the highest vector in service to form a processor priority. When a waiting request belongs to a class strictly above that priority, the block raises a request line toward the core.

The core takes an interrupt with a one-cycle acknowledge strobe. The response is combinational in the same cycle. If a request is deliverable, the block returns its vector and moves it from waiting to in-service at the clock edge. If a request is waiting but blocked, the block returns the spurious vector and leaves its state alone. An end-of-interrupt strobe retires the highest in-service vector. If that vector was level-triggered, and a suppression input does not forbid it, the block emits a one-cycle broadcast carrying the vector. An indexed read port exposes the state words and the priority registers.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset every request, in-service and trigger bit is zero, task priority and the spurious register are zero, `int_req` is low, and an acknowledge returns `ack_valid` low.
- R2: A set of vector n makes request bit n visible on the read port one cycle later. It appears in word n>>5 at bit n&31, with `rd_sel`=0 selecting requests, 1 in-service and 2 trigger mode. The trigger bit n is written to `set_level` (1 level, 0 edge).
- R3: The processor priority equals the task priority when its bits [7:4] are at least the class (bits [7:4]) of the highest in-service vector. Otherwise it equals that class shifted left by four. An empty in-service set counts as class 0. `rd_sel`=3 returns the processor priority in bits [15:8] and the task priority in bits [7:0].
- R4: `int_req` is high only when the block is enabled, a request is waiting, and either the processor priority is zero or the highest waiting vector's class is strictly greater than the processor-priority class.
- R5: An acknowledge while a request is deliverable gives `ack_valid`=1 with that vector on `ack_vec`. At the edge, the vector's request bit clears and its in-service bit sets.
- R6: An acknowledge while a request waits but is blocked gives `ack_valid`=1 with the low 8 bits of the spurious register, and changes no state.
- R7: Bit 8 of the 9-bit spurious register is the enable. While it is clear, `int_req` stays low, an acknowledge returns `ack_valid`=0 and moves nothing, and sets are still recorded.
- R8: End-of-interrupt clears the highest set in-service bit. When no in-service bit is set, it does nothing.
- R9: In the cycle after an end-of-interrupt that retires a vector whose trigger bit is 1, while `eoi_suppress` is low, `bcast_valid` is high for one cycle with the vector on `bcast_vec`. In every other case `bcast_valid` stays low.
- R10: The highest waiting or in-service vector is the largest vector number, searching words from 7 down to 0 and then the most significant bit within the word.
- R11: An acknowledge while no request waits returns `ack_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_valid | input | 1 | Record a request for `set_vec` |
| set_vec | input | 8 | Vector to request |
| set_level | input | 1 | Trigger mode of the request, 1 level |
| tpr_we | input | 1 | Write task priority |
| tpr_wdata | input | 8 | Task priority value |
| svr_we | input | 1 | Write spurious register |
| svr_wdata | input | 9 | Enable bit 8, spurious vector bits 7:0 |
| eoi_suppress | input | 1 | Forbid the level end-of-interrupt broadcast |
| ack_req | input | 1 | Core acknowledge strobe |
| ack_valid | output | 1 | Acknowledge returned a vector |
| ack_vec | output | 8 | Accepted vector or spurious vector |
| eoi_req | input | 1 | End-of-interrupt strobe |
| bcast_valid | output | 1 | Level end-of-interrupt broadcast pulse |
| bcast_vec | output | 8 | Vector being broadcast |
| int_req | output | 1 | Interrupt request toward the core |
| rd_sel | input | 2 | Read selector: 0 request, 1 in-service, 2 trigger, 3 priorities |
| rd_word | input | 3 | Word index for the state vectors |
| rd_data | output | 32 | Read data |

## Verification
The assertions assume a well-behaved core. An acknowledge is a single-cycle strobe. An acknowledge and an end-of-interrupt never arrive in the same cycle. A request set in the same cycle as an acknowledge of the same vector is allowed, and the set then wins. The stimulus issues every strobe for exactly one cycle between negative edges, never overlaps acknowledge with end-of-interrupt, and changes the task priority only while no strobe is active. As a result, the properties that track a vector across an edge always see the state the requirements describe.

// File: rtl/vpc_pkg.sv
// Package: shared sizes and read-port selector encoding for the
// local interrupt priority controller.
package vpc_pkg;
    localparam int VEC_W   = 8;
    localparam int N_VEC   = 1 << VEC_W;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = N_VEC / WORD_W;
    localparam int CLS_W   = 4;

    typedef enum logic [1:0] {
        RD_REQ  = 2'd0,
        RD_SERV = 2'd1,
        RD_TRIG = 2'd2,
        RD_PRIO = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/vpc_find_top.sv
// Module: finds the highest set bit of a wide vector.
// Assumes: N is a multiple of WORD_W. The search goes word by word,
// highest word first, then the most significant bit within that word.
module vpc_find_top #(
    parameter int N      = 256,
    parameter int WORD_W = 32,
    parameter int IW     = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    localparam int NW = N / WORD_W;
    localparam int BW = $clog2(WORD_W);

    logic [NW-1:0] w_any;
    logic [BW-1:0] w_msb [NW];

    genvar w;
    generate
        for (w = 0; w < NW; w++) begin : g_word
            // Per word: any bit set, and the position of its top bit.
            always_comb begin
                w_any[w] = |bits[w*WORD_W +: WORD_W];
                w_msb[w] = '0;
                for (int b = 0; b < WORD_W; b++) begin
                    if (bits[w*WORD_W + b]) w_msb[w] = BW'(b);
                end
            end
        end
    endgenerate

    // Across words: a higher non-empty word overrides a lower one.
    always_comb begin
        found = |w_any;
        idx   = '0;
        for (int k = 0; k < NW; k++) begin
            if (w_any[k]) idx = IW'((k << BW) | int'(w_msb[k]));
        end
    end
endmodule

// File: rtl/vpc_prio_eval.sv
// Module: derives the processor priority and decides deliverability.
// Assumes: vectors are VEC_W bits, the class is the top CLS_W bits.
module vpc_prio_eval #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             serv_found,
    input  logic [VEC_W-1:0] serv_top,
    input  logic             req_found,
    input  logic [VEC_W-1:0] req_top,
    output logic [VEC_W-1:0] ppr,
    output logic             deliverable
);
    localparam int LO_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] serv_cls;
    logic [CLS_W-1:0] tpr_cls;

    // Processor priority: the larger of the task priority and the serviced class.
    always_comb begin
        serv_cls = serv_found ? serv_top[VEC_W-1 -: CLS_W] : '0;
        tpr_cls  = tpr[VEC_W-1 -: CLS_W];
        ppr      = (tpr_cls >= serv_cls) ? tpr : {serv_cls, {LO_W{1'b0}}};
    end

    // Deliverable: a request above the priority class, or priority zero.
    always_comb begin
        deliverable = req_found &&
                      ((ppr == '0) || (req_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]));
    end
endmodule

// File: rtl/vec_prio_ctrl.sv
// Module: local interrupt priority controller top.
// Holds the request, in-service and trigger state for all vectors, the
// task priority and the spurious register. It answers acknowledges,
// retires vectors on end-of-interrupt and broadcasts level retirements.
// Assumes: ack_req and eoi_req are single-cycle strobes, not both in one cycle.
module vec_prio_ctrl
    import vpc_pkg::*;
#(
    parameter int P_VEC_W  = VEC_W,
    parameter int P_WORD_W = WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_valid,
    input  logic [P_VEC_W-1:0]  set_vec,
    input  logic                set_level,
    input  logic                tpr_we,
    input  logic [P_VEC_W-1:0]  tpr_wdata,
    input  logic                svr_we,
    input  logic [P_VEC_W:0]    svr_wdata,
    input  logic                eoi_suppress,
    input  logic                ack_req,
    output logic                ack_valid,
    output logic [P_VEC_W-1:0]  ack_vec,
    input  logic                eoi_req,
    output logic                bcast_valid,
    output logic [P_VEC_W-1:0]  bcast_vec,
    output logic                int_req,
    input  logic [1:0]          rd_sel,
    input  logic [$clog2((1 << P_VEC_W) / P_WORD_W)-1:0] rd_word,
    output logic [P_WORD_W-1:0] rd_data
);
    localparam int NV = 1 << P_VEC_W;
    localparam logic [NV-1:0] ONE = {{(NV-1){1'b0}}, 1'b1};

    logic [NV-1:0]      irr_q, isr_q, tmr_q;
    logic [P_VEC_W-1:0] tpr_q;
    logic [P_VEC_W:0]   svr_q;
    logic               enabled;

    logic               irr_found, isr_found, deliverable;
    logic [P_VEC_W-1:0] irr_top, isr_top, ppr;
    logic               ack_take, eoi_hit;
    logic [NV-1:0]      set_mask, take_mask, eoi_mask;

    // Highest waiting request.
    vpc_find_top #(.N(NV), .WORD_W(P_WORD_W), .IW(P_VEC_W)) u_find_req (
        .bits(irr_q), .found(irr_found), .idx(irr_top)
    );

    // Highest vector in service.
    vpc_find_top #(.N(NV), .WORD_W(P_WORD_W), .IW(P_VEC_W)) u_find_serv (
        .bits(isr_q), .found(isr_found), .idx(isr_top)
    );

    // Priority and acceptance decision.
    vpc_prio_eval #(.VEC_W(P_VEC_W), .CLS_W(CLS_W)) u_eval (
        .tpr(tpr_q), .serv_found(isr_found), .serv_top(isr_top),
        .req_found(irr_found), .req_top(irr_top),
        .ppr(ppr), .deliverable(deliverable)
    );

    // Acknowledge response and the masks that update the state vectors.
    always_comb begin
        enabled   = svr_q[P_VEC_W];
        int_req   = enabled && deliverable;
        ack_valid = ack_req && enabled && irr_found;
        ack_vec   = deliverable ? irr_top : svr_q[P_VEC_W-1:0];
        ack_take  = ack_req && enabled && deliverable;
        eoi_hit   = eoi_req && isr_found;
        set_mask  = set_valid ? (ONE << set_vec) : '0;
        take_mask = ack_take  ? (ONE << irr_top) : '0;
        eoi_mask  = eoi_hit   ? (ONE << isr_top) : '0;
    end

    // State vectors: a set overrides a same-cycle take of the same vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= (irr_q & ~take_mask) | set_mask;
            isr_q <= (isr_q & ~eoi_mask) | take_mask;
            if (set_valid) tmr_q[set_vec] <= set_level;
        end
    end

    // Software-written priority and spurious registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            svr_q <= '0;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata;
        end
    end

    // Level end-of-interrupt broadcast, one cycle after the retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcast_valid <= 1'b0;
            bcast_vec   <= '0;
        end else begin
            bcast_valid <= eoi_hit && tmr_q[isr_top] && !eoi_suppress;
            bcast_vec   <= isr_top;
        end
    end

    // Indexed read port over the state words and priority registers.
    always_comb begin
        unique case (rd_sel)
            RD_REQ:  rd_data = irr_q[int'(rd_word)*P_WORD_W +: P_WORD_W];
            RD_SERV: rd_data = isr_q[int'(rd_word)*P_WORD_W +: P_WORD_W];
            RD_TRIG: rd_data = tmr_q[int'(rd_word)*P_WORD_W +: P_WORD_W];
            default: rd_data = P_WORD_W'({ppr, tpr_q});
        endcase
    end

    AST_SET_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> irr_q[$past(set_vec)] && (tmr_q[$past(set_vec)] == $past(set_level))); // R2

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[P_VEC_W-1 -: CLS_W] >= tpr_q[P_VEC_W-1 -: CLS_W]); // R3

    AST_REQ_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> svr_q[P_VEC_W] && irr_q[irr_top] &&
                    ((ppr == '0) || (irr_top[P_VEC_W-1 -: CLS_W] > ppr[P_VEC_W-1 -: CLS_W]))); // R4

    AST_ACK_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !(set_valid && set_vec == irr_top))
        |=> isr_q[$past(irr_top)] && !irr_q[$past(irr_top)]); // R5

    AST_SPURIOUS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !deliverable && !set_valid && !eoi_req)
        |=> $stable(irr_q) && $stable(isr_q)); // R6

    AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && isr_found && !ack_req) |=> !isr_q[$past(isr_top)]); // R8

    AST_BCAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |-> $past(eoi_req) && !$past(eoi_suppress)); // R9
endmodule

// File: tb/tb_vec_prio_ctrl.sv
`timescale 1ns/1ps
// Bench: table-driven priority cases, then directed reset and corner tests.
module tb_vec_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_valid = 1'b0, set_level = 1'b0;
    logic [7:0]  set_vec = '0;
    logic        tpr_we = 1'b0, svr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic [8:0]  svr_wdata = '0;
    logic        eoi_suppress = 1'b0, ack_req = 1'b0, eoi_req = 1'b0;
    logic        ack_valid, bcast_valid, int_req;
    logic [7:0]  ack_vec, bcast_vec;
    logic [1:0]  rd_sel = '0;
    logic [2:0]  rd_word = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    vec_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
        .set_level(set_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata), .eoi_suppress(eoi_suppress),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi_req(eoi_req), .bcast_valid(bcast_valid), .bcast_vec(bcast_vec),
        .int_req(int_req), .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data)
    );

    always #4 clk = ~clk;

    // Fields: serviced vector (0 none), tpr, pending vector, int_req, ack vector, ppr.
    localparam int NROW = 8;
    localparam logic [40:0] TBL [NROW] = '{
        {8'h00, 8'h00, 8'h21, 1'b1, 8'h21, 8'h00},
        {8'h00, 8'h20, 8'h25, 1'b0, 8'h3F, 8'h20},
        {8'h00, 8'h20, 8'h31, 1'b1, 8'h31, 8'h20},
        {8'h50, 8'h10, 8'h55, 1'b0, 8'h3F, 8'h50},
        {8'h50, 8'h10, 8'h61, 1'b1, 8'h61, 8'h50},
        {8'h40, 8'h70, 8'h65, 1'b0, 8'h3F, 8'h70},
        {8'h00, 8'h0F, 8'h05, 1'b0, 8'h3F, 8'h0F},
        {8'h00, 8'hFF, 8'hFE, 1'b0, 8'h3F, 8'hFF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic set_v(input logic [7:0] v, input logic lvl);
        set_valid = 1'b1; set_vec = v; set_level = lvl;
        step();
        set_valid = 1'b0;
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        tpr_we = 1'b1; tpr_wdata = v; step(); tpr_we = 1'b0;
    endtask

    task automatic wr_svr(input logic [8:0] v);
        svr_we = 1'b1; svr_wdata = v; step(); svr_we = 1'b0;
    endtask

    task automatic ack(output logic v, output logic [7:0] vec);
        ack_req = 1'b1; #1;
        v = ack_valid; vec = ack_vec;
        step();
        ack_req = 1'b0;
    endtask

    task automatic eoi(output logic bv, output logic [7:0] bvec);
        eoi_req = 1'b1;
        step();
        eoi_req = 1'b0; #1;
        bv = bcast_valid; bvec = bcast_vec;
    endtask

    task automatic rd(input logic [1:0] s, input logic [2:0] w, output logic [31:0] d);
        rd_sel = s; rd_word = w; #1; d = rd_data;
    endtask

    initial begin
        logic        v;
        logic [7:0]  vec;
        logic [31:0] d;
        do_reset();

        // R1: reset state
        #1; chk("R1 int_req", 32'(int_req), 0);
        rd(2'd0, 3'd0, d); chk("R1 req word0", d, 0);
        rd(2'd1, 3'd7, d); chk("R1 serv word7", d, 0);
        rd(2'd2, 3'd3, d); chk("R1 trig word3", d, 0);
        rd(2'd3, 3'd0, d); chk("R1 prio", d, 0);
        ack(v, vec); chk("R1 ack_valid", 32'(v), 0);

        // R7: disabled block records sets but never requests or accepts
        set_v(8'h30, 1'b0); #1;
        chk("R7 int_req disabled", 32'(int_req), 0);
        ack(v, vec); chk("R7 ack disabled", 32'(v), 0);
        rd(2'd0, 3'd1, d); chk("R7 set recorded", d, 32'h0001_0000);
        rd(2'd1, 3'd1, d); chk("R7 nothing in service", d, 0);

        // Table walk: R3 priority, R4 request, R5/R6 acknowledge
        for (int i = 0; i < NROW; i++) begin
            logic [7:0] t_isr, t_tpr, t_irr, t_ack, t_ppr;
            logic       t_req;
            {t_isr, t_tpr, t_irr, t_req, t_ack, t_ppr} = TBL[i];
            do_reset();
            wr_svr(9'h13F);
            if (t_isr != 8'h00) begin
                set_v(t_isr, 1'b0);
                ack(v, vec);
            end
            wr_tpr(t_tpr);
            set_v(t_irr, 1'b0); #1;
            chk("R4 int_req row", 32'(int_req), 32'(t_req));
            rd(2'd3, 3'd0, d); chk("R3 ppr/tpr row", d, {16'h0, t_ppr, t_tpr});
            ack(v, vec);
            chk("R5 R6 ack_valid row", 32'(v), 1);
            chk("R5 R6 ack_vec row", 32'(vec), 32'(t_ack));
            rd(2'd0, t_irr[7:5], d);
            chk("R5 R6 request after ack", d, t_req ? 32'h0 : (32'h1 << t_irr[4:0]));
        end

        // R2: bit placement and trigger mode
        do_reset();
        set_v(8'h9C, 1'b1);
        rd(2'd0, 3'd4, d); chk("R2 request word4", d, 32'h1000_0000);
        rd(2'd2, 3'd4, d); chk("R2 trig level", d, 32'h1000_0000);
        set_v(8'h9C, 1'b0);
        rd(2'd2, 3'd4, d); chk("R2 trig edge", d, 0);

        // R10: highest vector across and within words
        do_reset();
        wr_svr(9'h1FF);
        set_v(8'h45, 1'b0); set_v(8'h4A, 1'b0); set_v(8'h23, 1'b0); set_v(8'hE1, 1'b0);
        ack(v, vec); chk("R10 top across words", 32'(vec), 32'hE1);
        rd(2'd0, 3'd7, d); chk("R5 request cleared", d, 0);
        rd(2'd1, 3'd7, d); chk("R5 in service set", d, 32'h2);
        eoi(v, vec);
        ack(v, vec); chk("R10 top within word", 32'(vec), 32'h4A);

        // R11: acknowledge with nothing waiting
        do_reset();
        wr_svr(9'h1FF);
        ack(v, vec); chk("R11 empty ack", 32'(v), 0);

        // R8/R9: retirement order and level broadcast
        set_v(8'h72, 1'b0); ack(v, vec);
        set_v(8'h81, 1'b1); ack(v, vec);
        chk("R5 nested accept", 32'(vec), 32'h81);
        eoi(v, vec);
        chk("R9 bcast valid", 32'(v), 1);
        chk("R9 bcast vec", 32'(vec), 32'h81);
        step(); #1; chk("R9 one cycle", 32'(bcast_valid), 0);
        rd(2'd1, 3'd4, d); chk("R8 highest retired", d, 0);
        rd(2'd1, 3'd3, d); chk("R8 lower kept", d, 32'h0004_0000);
        eoi(v, vec); chk("R9 no bcast on edge", 32'(v), 0);
        rd(2'd1, 3'd3, d); chk("R8 second retire", d, 0);
        eoi(v, vec); chk("R8 empty eoi no bcast", 32'(v), 0);
        rd(2'd1, 3'd3, d); chk("R8 empty eoi state", d, 0);
        eoi_suppress = 1'b1;
        set_v(8'h91, 1'b1); ack(v, vec);
        eoi(v, vec); chk("R9 suppressed", 32'(v), 0);
        rd(2'd1, 3'd4, d); chk("R8 suppressed retire", d, 0);
        eoi_suppress = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule